// File: doc/BRIEF.md
# Guarded Flash Reprogramming Control Register

This block is the memory-mapped control and status register that sits in front of an on-chip flash controller and decides when the CPU may reprogram the array. Software reads a live ready flag. It enables reprogramming mode, overrides block locks, holds the flash controller in reset and picks the user ROM area over the boot ROM area. Each enable that could damage the array is armed by a write of 0 followed at once by a write of 1. A single stray write therefore cannot turn it on.

While reprogramming mode is on, the block forwards flash command and data writes to the controller as a one-cycle strobe. It forwards only 16-bit writes to even addresses and drops all others. Four abort sources clear the register and pulse the flash controller reset: NMI, watchdog interrupt, the external reset pin and software reset. An abort that lands during a program or erase marks the target block invalid. An erase that completes with the lock override on sends a pulse to the lock storage so that the block's lock is dropped.

Top module: `flash_ctl_guard`

## Requirements
- R1: Register bit 0 reads 1 when `wsmBusy` is low and 0 when it is high, tracking the input in the same cycle.
- R2: Bit 1 (reprogramming mode, `progModeEn`) is set only by a register write with bit 1 = 1 whose previous register write had bit 1 = 0. Any write with bit 1 = 0 clears it. A write of 1 without that preceding 0 leaves it unchanged.
- R3: Bit 2 (lock override, `lockOverrideEn`) arms and sets with the same 0-then-1 pair, counting only writes made while bit 1 was already 1. A write made while bit 1 is 0 neither changes it nor arms it. Any write that clears bit 1 also clears bit 2.
- R4: A write with bit 3 = 1 while bit 1 is already 1 sets bit 3 and drives `flashCtlRst` high. A write with bit 3 = 0 clears it in every mode.
- R5: Bit 5 takes the written value only while `bootMode` is high and keeps its value otherwise. `userRomSel` equals bit 5 AND `bootMode`.
- R6: Bits 4, 6 and 7 always read 0, and writes to them and to bit 0 have no effect. The read layout is {0, 0, bit5, 0, bit3, bit2, bit1, ready}.
- R7: A cycle with `nmiReq`, `wdtReq` or `swRstReq` high, or with `extRstN` low, clears bits 1, 2, 3 and 5 and both arming states at the next edge. It also raises `flashCtlRst` for exactly one cycle after that edge.
- R8: An abort cycle (R7) with `wsmBusy` high sets `blockInvalid[wsmBlock]`. An abort cycle with `wsmBusy` low sets no flag. A set flag clears after a cycle with `regRdEn` high, or after a cycle with `wsmDone` and `wsmIsErase` high for that same block. An erase done on any other block leaves it set.
- R9: A cycle with `wsmDone` and `wsmIsErase` high while `lockOverrideEn` is 1 produces `unlockPulse` for one cycle after the next edge, with `unlockBlock` = that cycle's `wsmBlock`. A program completion (`wsmIsErase` = 0) or an erase while the override is off gives no pulse.
- R10: A cycle with `cmdWrEn`, `cmdWide` = 1 (16-bit write) and `cmdAddr[0]` = 0 while bit 1 is 1 drives `cmdStrobe` high after the next edge, with `cmdOutAddr`/`cmdOutData` carrying that write. All other command writes are discarded.
- R11: While `porN` is low, every output is 0 except the ready bit in `regRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| extRstN | input | 1 | External reset pin, active low, handled as a synchronous abort |
| nmiReq | input | 1 | NMI request, abort source |
| wdtReq | input | 1 | Watchdog interrupt request, abort source |
| swRstReq | input | 1 | Software reset request, abort source |
| bootMode | input | 1 | High when the chip is running from the boot ROM |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe, clears block-invalid flags |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| cmdWrEn | input | 1 | Flash command/data write strobe |
| cmdAddr | input | ADDR_W | Byte address of the command write |
| cmdWide | input | 1 | 1 = 16-bit write, 0 = byte write |
| cmdData | input | CMD_W | Command/data value |
| cmdStrobe | output | 1 | Accepted command, one cycle |
| cmdOutAddr | output | ADDR_W | Address of the accepted command |
| cmdOutData | output | CMD_W | Data of the accepted command |
| wsmBusy | input | 1 | Erase/program state machine running |
| wsmDone | input | 1 | Erase/program completed this cycle |
| wsmIsErase | input | 1 | Current operation is an erase |
| wsmBlock | input | BLK_W | Target block of the current operation |
| progModeEn | output | 1 | Reprogramming mode enable |
| lockOverrideEn | output | 1 | Lock override enable |
| flashCtlRst | output | 1 | Flash controller reset |
| userRomSel | output | 1 | User ROM area selected in boot mode |
| unlockPulse | output | 1 | Force-unlock request to lock storage |
| unlockBlock | output | BLK_W | Block to unlock |
| blockInvalid | output | NUM_BLK | Per-block invalid flags |

## Verification
The bench sweeps every three-write sequence over bits 1, 2, 3 and 5 in both boot modes. In half of the sequences it also sets the unused bits. This exposes a design that sets a protected bit on a lone 1, or keeps the arming state across an intervening 1 or across an ignored write. It also catches one that lets bit 2 or bit 3 act before bit 1 was set, or that stores bit 5 outside boot mode. Each abort source is checked for clearing both the bits and the arming state. A design that only cleared the bits would then accept a single write of 1. The block-invalid flag is checked per block against a foreign erase, and the command filter is swept over address parity, width and mode. A filter that ignored address bit 0 or the width would forward byte writes or odd-address writes.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  localparam int REG_W    = 8;
  localparam int BIT_RDY  = 0;
  localparam int BIT_MODE = 1;
  localparam int BIT_LOCK = 2;
  localparam int BIT_FRST = 3;
  localparam int BIT_ROM  = 5;

  typedef struct packed {
    logic clrAll;
    logic modeSet;
    logic modeClr;
    logic lockSet;
    logic lockClr;
    logic frstSet;
    logic frstClr;
    logic romWr;
    logic romVal;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_ctl_control.sv
module flash_ctl_control
  import flash_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  logic             extRstN,
  input  logic             nmiReq,
  input  logic             wdtReq,
  input  logic             swRstReq,
  input  logic             bootMode,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             modeNow,
  output logic             abortReq,
  output ctlStrobe_t       strobe
);

  logic armMode;
  logic armLock;

  assign abortReq = nmiReq | wdtReq | swRstReq | ~extRstN;

  always_comb begin
    strobe        = '0;
    strobe.clrAll = abortReq;
    if (regWrEn && !abortReq) begin
      strobe.modeClr = ~regWrData[BIT_MODE];
      strobe.modeSet = regWrData[BIT_MODE] & armMode;
      if (modeNow) begin
        strobe.lockClr = ~regWrData[BIT_LOCK];
        strobe.lockSet = regWrData[BIT_LOCK] & armLock;
      end
      if (!regWrData[BIT_MODE]) begin
        strobe.lockClr = 1'b1;
      end
      strobe.frstClr = ~regWrData[BIT_FRST];
      strobe.frstSet = regWrData[BIT_FRST] & modeNow;
      strobe.romWr   = bootMode;
      strobe.romVal  = regWrData[BIT_ROM];
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      armMode <= 1'b0;
      armLock <= 1'b0;
    end else if (abortReq) begin
      armMode <= 1'b0;
      armLock <= 1'b0;
    end else if (regWrEn) begin
      armMode <= ~regWrData[BIT_MODE];
      armLock <= modeNow & ~regWrData[BIT_LOCK];
    end
  end

endmodule

// File: rtl/flash_ctl_datapath.sv
module flash_ctl_datapath
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  ctlStrobe_t        strobe,
  input  logic              bootMode,
  input  logic              wsmBusy,
  input  logic              cmdWrEn,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdWide,
  input  logic [CMD_W-1:0]  cmdData,
  output logic [REG_W-1:0]  regRdData,
  output logic              modeQ,
  output logic              lockQ,
  output logic              flashCtlRst,
  output logic              userRomSel,
  output logic              cmdStrobe,
  output logic [ADDR_W-1:0] cmdOutAddr,
  output logic [CMD_W-1:0]  cmdOutData
);

  logic frstQ;
  logic romQ;
  logic abortQ;
  logic cmdTake;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      modeQ  <= 1'b0;
      lockQ  <= 1'b0;
      frstQ  <= 1'b0;
      romQ   <= 1'b0;
      abortQ <= 1'b0;
    end else begin
      abortQ <= strobe.clrAll;
      if (strobe.clrAll) begin
        modeQ <= 1'b0;
        lockQ <= 1'b0;
        frstQ <= 1'b0;
        romQ  <= 1'b0;
      end else begin
        if (strobe.modeClr)      modeQ <= 1'b0;
        else if (strobe.modeSet) modeQ <= 1'b1;
        if (strobe.lockClr)      lockQ <= 1'b0;
        else if (strobe.lockSet) lockQ <= 1'b1;
        if (strobe.frstClr)      frstQ <= 1'b0;
        else if (strobe.frstSet) frstQ <= 1'b1;
        if (strobe.romWr)        romQ  <= strobe.romVal;
      end
    end
  end

  assign cmdTake = cmdWrEn & cmdWide & ~cmdAddr[0] & modeQ & ~strobe.clrAll;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cmdStrobe  <= 1'b0;
      cmdOutAddr <= '0;
      cmdOutData <= '0;
    end else begin
      cmdStrobe <= cmdTake;
      if (cmdTake) begin
        cmdOutAddr <= cmdAddr;
        cmdOutData <= cmdData;
      end
    end
  end

  always_comb begin
    regRdData           = '0;
    regRdData[BIT_RDY]  = ~wsmBusy;
    regRdData[BIT_MODE] = modeQ;
    regRdData[BIT_LOCK] = lockQ;
    regRdData[BIT_FRST] = frstQ;
    regRdData[BIT_ROM]  = romQ;
  end

  assign flashCtlRst = frstQ | abortQ;
  assign userRomSel  = romQ & bootMode;

endmodule

// File: rtl/flash_ctl_blocks.sv
module flash_ctl_blocks #(
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               abortReq,
  input  logic               regRdEn,
  input  logic               lockOn,
  input  logic               wsmBusy,
  input  logic               wsmDone,
  input  logic               wsmIsErase,
  input  logic [BLK_W-1:0]   wsmBlock,
  output logic               unlockPulse,
  output logic [BLK_W-1:0]   unlockBlock,
  output logic [NUM_BLK-1:0] blockInvalid
);

  logic eraseDone;
  assign eraseDone = wsmDone & wsmIsErase;

  for (genvar k = 0; k < NUM_BLK; k++) begin : gBlk
    logic hitK;
    assign hitK = (wsmBlock == BLK_W'(k));
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        blockInvalid[k] <= 1'b0;
      end else if (abortReq && wsmBusy && hitK) begin
        blockInvalid[k] <= 1'b1;
      end else if (regRdEn || (eraseDone && hitK)) begin
        blockInvalid[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      unlockPulse <= 1'b0;
      unlockBlock <= '0;
    end else begin
      unlockPulse <= eraseDone & lockOn & ~abortReq;
      if (eraseDone) begin
        unlockBlock <= wsmBlock;
      end
    end
  end

endmodule

// File: rtl/flash_ctl_guard.sv
module flash_ctl_guard
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CMD_W   = 16,
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               extRstN,
  input  logic               nmiReq,
  input  logic               wdtReq,
  input  logic               swRstReq,
  input  logic               bootMode,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  input  logic               cmdWrEn,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic               cmdWide,
  input  logic [CMD_W-1:0]   cmdData,
  output logic               cmdStrobe,
  output logic [ADDR_W-1:0]  cmdOutAddr,
  output logic [CMD_W-1:0]   cmdOutData,
  input  logic               wsmBusy,
  input  logic               wsmDone,
  input  logic               wsmIsErase,
  input  logic [BLK_W-1:0]   wsmBlock,
  output logic               progModeEn,
  output logic               lockOverrideEn,
  output logic               flashCtlRst,
  output logic               userRomSel,
  output logic               unlockPulse,
  output logic [BLK_W-1:0]   unlockBlock,
  output logic [NUM_BLK-1:0] blockInvalid
);

  ctlStrobe_t strobe;
  logic       abortReq;

  flash_ctl_control uCtl (
    .clk       (clk),
    .porN      (porN),
    .extRstN   (extRstN),
    .nmiReq    (nmiReq),
    .wdtReq    (wdtReq),
    .swRstReq  (swRstReq),
    .bootMode  (bootMode),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .modeNow   (progModeEn),
    .abortReq  (abortReq),
    .strobe    (strobe)
  );

  flash_ctl_datapath #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) uDp (
    .clk         (clk),
    .porN        (porN),
    .strobe      (strobe),
    .bootMode    (bootMode),
    .wsmBusy     (wsmBusy),
    .cmdWrEn     (cmdWrEn),
    .cmdAddr     (cmdAddr),
    .cmdWide     (cmdWide),
    .cmdData     (cmdData),
    .regRdData   (regRdData),
    .modeQ       (progModeEn),
    .lockQ       (lockOverrideEn),
    .flashCtlRst (flashCtlRst),
    .userRomSel  (userRomSel),
    .cmdStrobe   (cmdStrobe),
    .cmdOutAddr  (cmdOutAddr),
    .cmdOutData  (cmdOutData)
  );

  flash_ctl_blocks #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) uBlk (
    .clk          (clk),
    .porN         (porN),
    .abortReq     (abortReq),
    .regRdEn      (regRdEn),
    .lockOn       (lockOverrideEn),
    .wsmBusy      (wsmBusy),
    .wsmDone      (wsmDone),
    .wsmIsErase   (wsmIsErase),
    .wsmBlock     (wsmBlock),
    .unlockPulse  (unlockPulse),
    .unlockBlock  (unlockBlock),
    .blockInvalid (blockInvalid)
  );

endmodule

// File: rtl/flash_ctl_guard_chk.sv
module flash_ctl_guard_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              porN,
  input logic              extRstN,
  input logic              nmiReq,
  input logic              wdtReq,
  input logic              swRstReq,
  input logic              bootMode,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic              cmdWrEn,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              cmdWide,
  input logic              cmdStrobe,
  input logic              wsmBusy,
  input logic              wsmDone,
  input logic              wsmIsErase,
  input logic              progModeEn,
  input logic              lockOverrideEn,
  input logic              userRomSel,
  input logic              unlockPulse
);

  logic anyAbort;
  assign anyAbort = nmiReq | wdtReq | swRstReq | ~extRstN;

  AST_READY_LIVE: assert property (@(posedge clk) disable iff (!porN)
    regRdData[0] == !wsmBusy); // R1

  AST_MODE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!porN)
    $rose(progModeEn) |-> $past(regWrEn && regWrData[1])); // R2

  AST_LOCK_NEEDS_MODE: assert property (@(posedge clk) disable iff (!porN)
    lockOverrideEn |-> progModeEn); // R3

  AST_ROM_NEEDS_BOOT: assert property (@(posedge clk) disable iff (!porN)
    userRomSel |-> bootMode); // R5

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!porN)
    regRdData[7:6] == 2'b00 && regRdData[4] == 1'b0); // R6

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!porN)
    anyAbort |=> !progModeEn && !lockOverrideEn); // R7

  AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!porN)
    unlockPulse |-> $past(wsmDone && wsmIsErase && lockOverrideEn)); // R9

  AST_CMD_FILTER: assert property (@(posedge clk) disable iff (!porN)
    cmdStrobe |-> $past(cmdWrEn && cmdWide && !cmdAddr[0] && progModeEn)); // R10

endmodule

bind flash_ctl_guard flash_ctl_guard_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk            (clk),
  .porN           (porN),
  .extRstN        (extRstN),
  .nmiReq         (nmiReq),
  .wdtReq         (wdtReq),
  .swRstReq       (swRstReq),
  .bootMode       (bootMode),
  .regWrEn        (regWrEn),
  .regWrData      (regWrData),
  .regRdData      (regRdData),
  .cmdWrEn        (cmdWrEn),
  .cmdAddr        (cmdAddr),
  .cmdWide        (cmdWide),
  .cmdStrobe      (cmdStrobe),
  .wsmBusy        (wsmBusy),
  .wsmDone        (wsmDone),
  .wsmIsErase     (wsmIsErase),
  .progModeEn     (progModeEn),
  .lockOverrideEn (lockOverrideEn),
  .userRomSel     (userRomSel),
  .unlockPulse    (unlockPulse)
);

// File: tb/tb_flash_ctl_guard.sv
`timescale 1ns/1ps
module tb_flash_ctl_guard;

  localparam int ADDR_W  = 8;
  localparam int CMD_W   = 16;
  localparam int NUM_BLK = 4;
  localparam int BLK_W   = 2;

  logic clk = 1'b0;
  logic porN, extRstN, nmiReq, wdtReq, swRstReq, bootMode;
  logic regWrEn, regRdEn;
  logic [7:0] regWrData, regRdData;
  logic cmdWrEn, cmdWide, cmdStrobe;
  logic [ADDR_W-1:0] cmdAddr, cmdOutAddr;
  logic [CMD_W-1:0] cmdData, cmdOutData;
  logic wsmBusy, wsmDone, wsmIsErase;
  logic [BLK_W-1:0] wsmBlock, unlockBlock;
  logic progModeEn, lockOverrideEn, flashCtlRst, userRomSel, unlockPulse;
  logic [NUM_BLK-1:0] blockInvalid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // model state
  bit eM1, eM2, eM3, eM5, eArm1, eArm2;

  always #2.5 clk = ~clk;

  flash_ctl_guard #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) dut (
    .clk(clk), .porN(porN), .extRstN(extRstN), .nmiReq(nmiReq), .wdtReq(wdtReq),
    .swRstReq(swRstReq), .bootMode(bootMode), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .cmdWrEn(cmdWrEn), .cmdAddr(cmdAddr),
    .cmdWide(cmdWide), .cmdData(cmdData), .cmdStrobe(cmdStrobe), .cmdOutAddr(cmdOutAddr),
    .cmdOutData(cmdOutData), .wsmBusy(wsmBusy), .wsmDone(wsmDone), .wsmIsErase(wsmIsErase),
    .wsmBlock(wsmBlock), .progModeEn(progModeEn), .lockOverrideEn(lockOverrideEn),
    .flashCtlRst(flashCtlRst), .userRomSel(userRomSel), .unlockPulse(unlockPulse),
    .unlockBlock(unlockBlock), .blockInvalid(blockInvalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic regWr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    step();
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic pulseSwRst();
    swRstReq = 1'b1; step(); swRstReq = 1'b0;
  endtask

  task automatic modelClear();
    eM1 = 0; eM2 = 0; eM3 = 0; eM5 = 0; eArm1 = 0; eArm2 = 0;
  endtask

  // expected effect of one register write, from R2..R6
  task automatic modelWrite(input logic [7:0] d);
    bit oldMode;
    oldMode = eM1;
    if (!d[1]) eM1 = 0; else if (eArm1) eM1 = 1;
    eArm1 = !d[1];
    if (oldMode) begin
      if (!d[2]) eM2 = 0; else if (eArm2) eM2 = 1;
      eArm2 = !d[2];
    end else begin
      eArm2 = 0;
    end
    if (!d[1]) eM2 = 0;
    if (!d[3]) eM3 = 0; else if (oldMode) eM3 = 1;
    if (bootMode) eM5 = d[5];
  endtask

  function automatic logic [7:0] mapNib(input int n, input bit ext);
    logic [7:0] d;
    d = 8'h00;
    d[1] = n[0]; d[2] = n[1]; d[3] = n[2]; d[5] = n[3];
    if (ext) d = d | 8'hD1;
    return d;
  endfunction

  task automatic enterModeLock();
    pulseSwRst();
    regWr(8'h00); regWr(8'h02); regWr(8'h02); regWr(8'h06);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    porN = 0; extRstN = 1; nmiReq = 0; wdtReq = 0; swRstReq = 0; bootMode = 0;
    regWrEn = 0; regRdEn = 0; regWrData = 0; cmdWrEn = 0; cmdAddr = 0; cmdWide = 0;
    cmdData = 0; wsmBusy = 0; wsmDone = 0; wsmIsErase = 0; wsmBlock = 0;
    step(); step();
    // R11 reset state
    chk("R11 rdData", 32'(regRdData), 32'h01);
    chk("R11 outputs", 32'({progModeEn, lockOverrideEn, flashCtlRst, userRomSel,
                            unlockPulse, cmdStrobe}), 32'h0);
    chk("R11 blockInvalid", 32'(blockInvalid), 32'h0);
    porN = 1; step();

    // R1 ready bit follows busy
    wsmBusy = 1'b1; #1;
    chk("R1 busy", 32'(regRdData[0]), 32'h0);
    wsmBusy = 1'b0; #1;
    chk("R1 ready", 32'(regRdData[0]), 32'h1);
    step();

    // R2 R3 R4 R5 R6 sweep of all three-write sequences
    for (int bm = 0; bm < 2; bm++) begin
      bootMode = bm[0];
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          for (int c = 0; c < 16; c++) begin
            bit ext;
            ext = ((a + b + c) % 2) == 1;
            pulseSwRst(); modelClear();
            regWr(mapNib(a, ext)); modelWrite(mapNib(a, ext));
            regWr(mapNib(b, ext)); modelWrite(mapNib(b, ext));
            regWr(mapNib(c, ext)); modelWrite(mapNib(c, ext));
            chk("R6 readback", 32'(regRdData),
                32'({2'b00, eM5, 1'b0, eM3, eM2, eM1, 1'b1}));
            chk("R2 progModeEn", 32'(progModeEn), 32'(eM1));
            chk("R3 lockOverrideEn", 32'(lockOverrideEn), 32'(eM2));
            chk("R4 flashCtlRst", 32'(flashCtlRst), 32'(eM3));
            chk("R5 userRomSel", 32'(userRomSel), 32'(eM5 & bm[0]));
          end
        end
      end
    end

    // R7 each abort source clears bits and arming
    for (int src = 0; src < 4; src++) begin
      bootMode = 1'b1;
      enterModeLock();
      regWr(8'h2E);
      chk("R7 setup", 32'(regRdData), 32'h2F);
      case (src)
        0: nmiReq = 1'b1;
        1: wdtReq = 1'b1;
        2: swRstReq = 1'b1;
        default: extRstN = 1'b0;
      endcase
      step();
      nmiReq = 0; wdtReq = 0; swRstReq = 0; extRstN = 1;
      chk("R7 cleared", 32'(regRdData), 32'h01);
      chk("R7 reset pulse", 32'(flashCtlRst), 32'h1);
      step();
      chk("R7 pulse one cycle", 32'(flashCtlRst), 32'h0);
      regWr(8'h02);
      chk("R7 arming cleared", 32'(progModeEn), 32'h0);
    end
    bootMode = 1'b0;

    // R10 command filter
    for (int md = 0; md < 2; md++) begin
      pulseSwRst();
      if (md == 1) begin regWr(8'h00); regWr(8'h02); end
      for (int ad = 0; ad < 8; ad++) begin
        for (int w = 0; w < 2; w++) begin
          bit expS;
          expS = (md == 1) && (w == 1) && (ad % 2 == 0);
          cmdWrEn = 1'b1; cmdAddr = ADDR_W'(ad + 8'h40); cmdWide = w[0];
          cmdData = CMD_W'(16'hA500 + ad * 2 + w);
          step();
          cmdWrEn = 1'b0;
          chk("R10 strobe", 32'(cmdStrobe), 32'(expS));
          if (expS) begin
            chk("R10 addr", 32'(cmdOutAddr), 32'(ad + 8'h40));
            chk("R10 data", 32'(cmdOutData), 32'(16'hA500 + ad * 2 + w));
          end
          step();
          chk("R10 strobe one cycle", 32'(cmdStrobe), 32'h0);
        end
      end
    end

    // R8 block invalid on abort during busy operation
    for (int k = 0; k < NUM_BLK; k++) begin
      wsmBusy = 1'b0; wsmBlock = BLK_W'(k); nmiReq = 1'b1; step(); nmiReq = 1'b0;
      chk("R8 idle abort sets nothing", 32'(blockInvalid), 32'h0);
      wsmBusy = 1'b1; wdtReq = 1'b1; step(); wdtReq = 1'b0; wsmBusy = 1'b0;
      chk("R8 flag set", 32'(blockInvalid), 32'(1 << k));
      wsmDone = 1'b1; wsmIsErase = 1'b1; wsmBlock = BLK_W'((k + 1) % NUM_BLK);
      step();
      chk("R8 other erase keeps flag", 32'(blockInvalid), 32'(1 << k));
      if (k % 2 == 0) begin
        wsmDone = 1'b0; wsmIsErase = 1'b0;
        regRdEn = 1'b1; step(); regRdEn = 1'b0;
        chk("R8 read clears", 32'(blockInvalid), 32'h0);
      end else begin
        wsmBlock = BLK_W'(k); step();
        wsmDone = 1'b0; wsmIsErase = 1'b0;
        chk("R8 erase clears", 32'(blockInvalid), 32'h0);
      end
    end

    // R9 unlock pulse on erase completion with override
    for (int k = 0; k < NUM_BLK; k++) begin
      enterModeLock();
      chk("R9 override on", 32'(lockOverrideEn), 32'h1);
      wsmDone = 1'b1; wsmIsErase = 1'b1; wsmBlock = BLK_W'(k); step();
      wsmDone = 1'b0; wsmIsErase = 1'b0;
      chk("R9 pulse", 32'(unlockPulse), 32'h1);
      chk("R9 block", 32'(unlockBlock), 32'(k));
      step();
      chk("R9 pulse one cycle", 32'(unlockPulse), 32'h0);
      wsmDone = 1'b1; wsmIsErase = 1'b0; step(); wsmDone = 1'b0;
      chk("R9 program no pulse", 32'(unlockPulse), 32'h0);
      regWr(8'h02);
      chk("R9 override off", 32'(lockOverrideEn), 32'h0);
      wsmDone = 1'b1; wsmIsErase = 1'b1; step(); wsmDone = 1'b0; wsmIsErase = 1'b0;
      chk("R9 no override no pulse", 32'(unlockPulse), 32'h0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule